// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Flush and DMA Requests

This block holds the audio samples that pass between a system bus and a serial audio port. A transmit queue is filled by bus writes and emptied one sample at a time by the serializer. A receive queue is filled by the deserializer and emptied by bus reads. Each direction can be flushed from software. Each direction keeps a running count of the samples that crossed to or from the serial side. Each direction raises a DMA request only when a four-word burst can be moved in full.

Software reaches the block through a small word-addressed register port. Index 0 is the transmit data port. Index 1 is the receive data port. Index 2 is FIFO control. Index 3 is FIFO status. Index 4 is DMA control. Index 5 is the transmit sample counter and index 6 is the receive sample counter. Read data is registered: it appears on the cycle after the read strobe. The serial side uses a take strobe on transmit and a put strobe on receive. Clocks and the serial framing lie outside this block.

Top module: `audio_fifo_dma`

## Requirements
- R1: After reset both queues are empty, both counters read 0, both DMA requests are low, `tx_ready` is low, and the control, status and DMA registers read 0.
- R2: Each write to index 0 appends `bus_wdata` to the transmit queue. `tx_sample` shows the oldest entry, and `tx_ready` is high while the queue is not empty. A `tx_take` pulse removes the oldest entry, so samples leave in the order they were written.
- R3: A `rx_put` pulse appends `rx_sample` to the receive queue. A read of index 1 returns the oldest entry and removes it.
- R4: Writing 1 to control bit 25 flushes the transmit queue. On the cycle after the write, control bit 25 reads back 1. One cycle later the bit reads 0, the transmit level is 0, and both transmit error flags are clear. The receive side is not affected.
- R5: Writing 1 to control bit 24 flushes the receive queue in the same way. The transmit side is not affected.
- R6: The transmit counter (index 5) rises by one for each sample actually taken by `tx_take`. A take from an empty queue does not count. A write of zero clears the counter. A write of any nonzero value is ignored. The counter wraps modulo 2^32.
- R7: The receive counter (index 6) rises by one for each sample actually accepted by `rx_put`. A write of zero clears it and a nonzero write is ignored.
- R8: `tx_dreq` is high exactly when DMA control bit 7 is set and the transmit queue has at least 4 free entries.
- R9: `rx_dreq` is high exactly when DMA control bit 3 is set and the receive queue holds at least 4 entries.
- R10: Bus writes to index 1 and index 3 have no effect. A read of index 0 returns 0 and does not change the transmit queue.
- R11: The status word at index 3 carries sticky error flags: bit 31 transmit overflow, bit 30 transmit underflow, bit 29 receive overflow, bit 28 receive underflow. Bits 15:8 give the transmit level and bits 7:0 the receive level. A push into a full queue is dropped and sets that queue's overflow flag. A take or read from an empty queue sets its underflow flag. Only a flush clears these flags.
- R12: Control bit 2 (transmit alignment mode) and bits 1:0 (receive mode) are stored, read back, and driven on `tx_align_mode` and `rx_align_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tx_take | input | 1 | Serializer takes the oldest transmit sample |
| tx_sample | output | 32 | Oldest transmit sample |
| tx_ready | output | 1 | Transmit queue is not empty |
| rx_put | input | 1 | Deserializer offers a sample |
| rx_sample | input | 32 | Sample offered on the receive side |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_align_mode | output | 1 | Stored transmit alignment mode |
| rx_align_mode | output | 2 | Stored receive mode |

## Verification
The transmit queue is filled one word at a time from empty to full and then past full. After every push, the request line and the status level are compared with the free-entry arithmetic. This locates the four-free threshold exactly and separates a dropped overflow push from a stored one. The receive queue is swept the same way against the held-entry threshold. Partial drains in both directions confirm ordering, and they confirm that only samples that really moved are counted. Each flush is applied while the other direction holds data and flags. This shows that the flush clears its own queue and flags, clears itself, and leaves the opposite direction intact.

// File: rtl/afd_pkg.sv
package afd_pkg;

  typedef enum logic [2:0] {
    IDX_TXDATA = 3'd0,
    IDX_RXDATA = 3'd1,
    IDX_CTRL   = 3'd2,
    IDX_STAT   = 3'd3,
    IDX_DMA    = 3'd4,
    IDX_TXCNT  = 3'd5,
    IDX_RXCNT  = 3'd6
  } afd_idx_e;

  localparam int BIT_TX_FLUSH = 25;
  localparam int BIT_RX_FLUSH = 24;
  localparam int BIT_TX_DRQ   = 7;
  localparam int BIT_RX_DRQ   = 3;
  localparam int BIT_TX_MODE  = 2;

  // Free entries are enough for one whole burst.
  function automatic logic room_for_burst(int lvl, int depth, int burst);
    return (depth - lvl) >= burst;
  endfunction

  // Held entries are enough for one whole burst.
  function automatic logic data_for_burst(int lvl, int burst);
    return lvl >= burst;
  endfunction

endpackage

// File: rtl/afd_fifo.sv
module afd_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              full,
  output logic              ovf,
  output logic              unf,
  output logic              push_ok,
  output logic              pop_ok
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IW-1:0]     wr_idx, rd_idx;
  logic [LVL_W-1:0]  count;

  function automatic logic [IW-1:0] step(logic [IW-1:0] idx);
    return (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == LVL_W'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem[rd_idx];
  assign level   = count;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      if (push_ok) wr_idx <= step(wr_idx);
      if (pop_ok)  rd_idx <= step(rd_idx);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) ovf <= 1'b1;
      if (pop && empty) unf <= 1'b1;
    end
  end

endmodule

// File: rtl/afd_counter.sv
module afd_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) value <= '0;
    else if (inc)      value <= value + 1'b1;
  end

endmodule

// File: rtl/audio_fifo_dma.sv
module audio_fifo_dma #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int BURST  = 4,
  parameter int CNT_W  = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_take,
  output logic [DATA_W-1:0] tx_sample,
  output logic              tx_ready,
  input  logic              rx_put,
  input  logic [DATA_W-1:0] rx_sample,
  output logic              tx_dreq,
  output logic              rx_dreq,
  output logic              tx_align_mode,
  output logic [1:0]        rx_align_mode
);
  import afd_pkg::*;

  logic tx_flush_q, rx_flush_q, tx_drq_en, rx_drq_en;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic tx_ovf, tx_unf, rx_ovf, rx_unf;
  logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic [DATA_W-1:0] rx_head;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;

  // named bus events
  logic wr_txdata, wr_ctrl, wr_dma, clr_txcnt, clr_rxcnt, rd_rxdata;
  assign wr_txdata = bus_wr && (bus_addr == IDX_TXDATA);
  assign wr_ctrl   = bus_wr && (bus_addr == IDX_CTRL);
  assign wr_dma    = bus_wr && (bus_addr == IDX_DMA);
  assign clr_txcnt = bus_wr && (bus_addr == IDX_TXCNT) && (bus_wdata == '0);
  assign clr_rxcnt = bus_wr && (bus_addr == IDX_RXCNT) && (bus_wdata == '0);
  assign rd_rxdata = bus_rd && (bus_addr == IDX_RXDATA);

  afd_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush_q),
    .push(wr_txdata), .push_data(bus_wdata), .pop(tx_take),
    .head(tx_sample), .level(tx_lvl), .empty(tx_empty), .full(tx_full),
    .ovf(tx_ovf), .unf(tx_unf), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  afd_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush_q),
    .push(rx_put), .push_data(rx_sample), .pop(rd_rxdata),
    .head(rx_head), .level(rx_lvl), .empty(rx_empty), .full(rx_full),
    .ovf(rx_ovf), .unf(rx_unf), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  afd_counter #(.CNT_W(CNT_W)) u_tx_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_txcnt), .inc(tx_pop_ok), .value(tx_cnt)
  );

  afd_counter #(.CNT_W(CNT_W)) u_rx_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_rxcnt), .inc(rx_push_ok), .value(rx_cnt)
  );

  // control: flush bits live for one cycle only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_flush_q    <= 1'b0;
      rx_flush_q    <= 1'b0;
      tx_align_mode <= 1'b0;
      rx_align_mode <= 2'b00;
      tx_drq_en     <= 1'b0;
      rx_drq_en     <= 1'b0;
    end else begin
      tx_flush_q <= wr_ctrl && bus_wdata[BIT_TX_FLUSH];
      rx_flush_q <= wr_ctrl && bus_wdata[BIT_RX_FLUSH];
      if (wr_ctrl) begin
        tx_align_mode <= bus_wdata[BIT_TX_MODE];
        rx_align_mode <= bus_wdata[1:0];
      end
      if (wr_dma) begin
        tx_drq_en <= bus_wdata[BIT_TX_DRQ];
        rx_drq_en <= bus_wdata[BIT_RX_DRQ];
      end
    end
  end

  assign tx_ready = !tx_empty;
  assign tx_dreq  = tx_drq_en && room_for_burst(int'(tx_lvl), DEPTH, BURST);
  assign rx_dreq  = rx_drq_en && data_for_burst(int'(rx_lvl), BURST);

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      IDX_RXDATA: rd_mux = rx_empty ? '0 : rx_head;
      IDX_CTRL: begin
        rd_mux[BIT_TX_FLUSH] = tx_flush_q;
        rd_mux[BIT_RX_FLUSH] = rx_flush_q;
        rd_mux[BIT_TX_MODE]  = tx_align_mode;
        rd_mux[1:0]          = rx_align_mode;
      end
      IDX_STAT: begin
        rd_mux[31]   = tx_ovf;
        rd_mux[30]   = tx_unf;
        rd_mux[29]   = rx_ovf;
        rd_mux[28]   = rx_unf;
        rd_mux[15:8] = 8'(tx_lvl);
        rd_mux[7:0]  = 8'(rx_lvl);
      end
      IDX_DMA: begin
        rd_mux[BIT_TX_DRQ] = tx_drq_en;
        rd_mux[BIT_RX_DRQ] = rx_drq_en;
      end
      IDX_TXCNT: rd_mux = DATA_W'(tx_cnt);
      IDX_RXCNT: rd_mux = DATA_W'(rx_cnt);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/afd_checker.sv
module afd_checker #(
  parameter int DEPTH = 8,
  parameter int BURST = 4,
  parameter int CNT_W = 32,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_flush,
  input logic             rx_flush,
  input logic [LVL_W-1:0] tx_lvl,
  input logic [LVL_W-1:0] rx_lvl,
  input logic             tx_dreq,
  input logic             rx_dreq,
  input logic             tx_ovf,
  input logic             rx_ovf,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt
);

  assert_tx_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_lvl == '0) && !tx_ovf);
  assert_tx_flush_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> !tx_flush);
  assert_rx_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_lvl == '0) && !rx_ovf);
  assert_rx_flush_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !rx_flush);
  assert_tx_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt != $past(tx_cnt)) |-> (tx_cnt == $past(tx_cnt) + 1'b1) || (tx_cnt == '0));
  assert_rx_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt != $past(rx_cnt)) |-> (rx_cnt == $past(rx_cnt) + 1'b1) || (rx_cnt == '0));
  assert_tx_dreq_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dreq |-> (int'(tx_lvl) <= DEPTH - BURST));
  assert_rx_dreq_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dreq |-> (int'(rx_lvl) >= BURST));
  assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_lvl) <= DEPTH) && (int'(rx_lvl) <= DEPTH));
  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !tx_flush) |=> tx_ovf);

endmodule

bind audio_fifo_dma afd_checker #(
  .DEPTH(DEPTH), .BURST(BURST), .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_afd_checker (
  .clk(clk), .rst_n(rst_n),
  .tx_flush(tx_flush_q), .rx_flush(rx_flush_q),
  .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
  .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
  .tx_ovf(tx_ovf), .rx_ovf(rx_ovf),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_audio_fifo_dma.sv
module test_audio_fifo_dma;

  localparam int DEPTH = 8;
  localparam int BURST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_take = 1'b0, rx_put = 1'b0;
  logic [31:0] tx_sample, rx_sample = '0;
  logic tx_ready, tx_dreq, rx_dreq, tx_align_mode;
  logic [1:0] rx_align_mode;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  audio_fifo_dma #(.DEPTH(DEPTH), .BURST(BURST)) i_audio_fifo_dma (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_take(tx_take), .tx_sample(tx_sample), .tx_ready(tx_ready),
    .rx_put(rx_put), .rx_sample(rx_sample), .tx_dreq(tx_dreq),
    .rx_dreq(rx_dreq), .tx_align_mode(tx_align_mode), .rx_align_mode(rx_align_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat(logic txo, logic txu, logic rxo, logic rxu,
                                       int txl, int rxl);
    return {txo, txu, rxo, rxu, 12'd0, 8'(txl), 8'(rxl)};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 tx_dreq", 32'(tx_dreq), 0);
    chk("R1 rx_dreq", 32'(rx_dreq), 0);
    chk("R1 tx_ready", 32'(tx_ready), 0);
    rd(3'd3, v); chk("R1 status", v, 0);
    rd(3'd2, v); chk("R1 control", v, 0);
    rd(3'd4, v); chk("R1 dma", v, 0);
    rd(3'd5, v); chk("R1 txcnt", v, 0);
    rd(3'd6, v); chk("R1 rxcnt", v, 0);

    // enable both requests: bit7 tx, bit3 rx
    wr(3'd4, 32'h88);
    chk("R8 tx_dreq empty", 32'(tx_dreq), 1);
    chk("R9 rx_dreq empty", 32'(rx_dreq), 0);

    // R2/R8 transmit fill sweep
    for (int i = 0; i < DEPTH; i++) begin
      wr(3'd0, 32'hA000_0000 + 32'(i * 3));
      chk("R8 tx_dreq sweep", 32'(tx_dreq), 32'((DEPTH - (i + 1)) >= BURST));
      chk("R2 tx_ready", 32'(tx_ready), 1);
      rd(3'd3, v); chk("R2 tx level", v, stat(0, 0, 0, 0, i + 1, 0));
    end
    // R11 overflow push dropped
    wr(3'd0, 32'hDEAD_BEEF);
    rd(3'd3, v); chk("R11 tx overflow", v, stat(1, 0, 0, 0, DEPTH, 0));

    // R10 access rules
    rd(3'd0, v); chk("R10 txdata reads zero", v, 0);
    wr(3'd1, 32'h55);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R10 rx/status writes ignored", v, stat(1, 0, 0, 0, DEPTH, 0));

    // R2/R6 drain five in order
    for (int i = 0; i < 5; i++) begin
      chk("R2 tx order", tx_sample, 32'hA000_0000 + 32'(i * 3));
      tx_take = 1'b1; tick(); tx_take = 1'b0;
    end
    chk("R8 tx_dreq at 3", 32'(tx_dreq), 1);
    rd(3'd5, v); chk("R6 txcnt five", v, 5);
    wr(3'd5, 32'd7);
    rd(3'd5, v); chk("R6 nonzero write ignored", v, 5);
    wr(3'd5, 32'd0);
    rd(3'd5, v); chk("R6 zero clears", v, 0);

    // R3/R9/R7 receive fill sweep
    for (int j = 0; j < DEPTH; j++) begin
      rx_sample = 32'h5000_0000 + 32'(j * 7);
      rx_put = 1'b1; tick(); rx_put = 1'b0;
      chk("R9 rx_dreq sweep", 32'(rx_dreq), 32'((j + 1) >= BURST));
    end
    rx_sample = 32'h1234_5678;
    rx_put = 1'b1; tick(); rx_put = 1'b0;
    rd(3'd6, v); chk("R7 rxcnt accepted only", v, DEPTH);
    for (int j = 0; j < 3; j++) begin
      rd(3'd1, v); chk("R3 rx order", v, 32'h5000_0000 + 32'(j * 7));
    end
    rd(3'd3, v); chk("R11 rx overflow", v, stat(1, 0, 1, 0, 3, DEPTH - 3));

    // R4 transmit flush with modes tx=1 rx=2
    wr(3'd2, (32'd1 << 25) | 32'h6);
    rd(3'd2, v); chk("R4 flush bit visible", v, (32'd1 << 25) | 32'h6);
    rd(3'd2, v); chk("R4 self clear R12 modes", v, 32'h6);
    chk("R12 tx mode pin", 32'(tx_align_mode), 1);
    chk("R12 rx mode pin", 32'(rx_align_mode), 2);
    rd(3'd3, v); chk("R4 tx emptied rx kept", v, stat(0, 0, 1, 0, 0, DEPTH - 3));
    chk("R2 tx_ready after flush", 32'(tx_ready), 0);

    // R11/R6 underflow is flagged and not counted
    tx_take = 1'b1; tick(); tx_take = 1'b0;
    rd(3'd3, v); chk("R11 tx underflow", v, stat(0, 1, 1, 0, 0, DEPTH - 3));
    rd(3'd5, v); chk("R6 empty take not counted", v, 0);

    // R5 receive flush keeps modes and tx flags
    wr(3'd2, (32'd1 << 24) | 32'h6);
    tick();
    rd(3'd3, v); chk("R5 rx emptied tx kept", v, stat(0, 1, 0, 0, 0, 0));
    chk("R9 rx_dreq after flush", 32'(rx_dreq), 0);
    rd(3'd1, v);
    rd(3'd3, v); chk("R11 rx underflow", v, stat(0, 1, 0, 1, 0, 0));
    wr(3'd6, 32'd0);
    rd(3'd6, v); chk("R7 zero clears", v, 0);

    // R8 disable gate
    wr(3'd4, 32'h0);
    chk("R8 tx_dreq gated", 32'(tx_dreq), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule